// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs the mandatory power-up command sequence of a single-data-rate SDRAM once reset is released. First it holds the command bus at NOP for a 100 µs settling stall. It then precharges every bank and issues two auto-refresh commands, each followed by its own full wait. Last comes a mode register load, and after the mode-load wait the block raises an initialization-done flag. Every wait is a cycle count that is fixed when the block is compiled, from the clock frequency and the memory timing parameters.

The done flag also works as the select of an output mux. While it is low, the sequencer owns chip select, the four command strobes, the address, the bank address and CKE, and the host-side command inputs have no effect. Once it is high, the host command generator's signals pass straight through to the memory pins. The flag stays high until the next asynchronous reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low the memory pins carry NOP, written {cs_n,ras_n,cas_n,we_n}=4'b0111. In the same state sd_cke_o=1 and init_done_o=0, and the address and bank are 0. Host inputs have no effect.
- R2: After reset is released, NOP is held for STALL_CYC = STALL_US*CLK_KHZ/1000 rising edges, which is 10000 at the defaults. All other sequencer outputs keep their reset values during this stall.
- R3: Right after that edge, precharge-all appears for one cycle, coded 4'b0010. During that cycle address bit 10 is 1, every other address bit is 0, and the bank is 0.
- R4: The first auto-refresh, coded 4'b0001, appears RP_CYC cycles after the precharge. RP_CYC is ceil(T_RP_NS*CLK_KHZ/1e6), with a minimum of 2, and equals 2 at the defaults.
- R5: The second auto-refresh appears RFC_CYC cycles after the first. RFC_CYC is ceil(T_RFC_NS*CLK_KHZ/1e6), with a minimum of 2, and equals 7 at the defaults.
- R6: The mode register load, coded 4'b0000, appears RFC_CYC cycles after the second refresh. During that cycle the address carries MODE_VAL (default 13'h033) and the bank carries MODE_BA (default 0).
- R7: init_done_o rises T_MRD_CYC cycles after the mode load (default 2). Every cycle of the sequence that is not a command cycle is NOP with address 0 and bank 0, and sd_cke_o stays 1 throughout.
- R8: Until init_done_o is high, the host inputs have no effect on the pins. Once it is high it stays high, and every pin equals the matching host input in the same cycle.
- R9: Asserting rst_ni low at any point, including in the middle of the sequence, forces NOP and init_done_o=0 at once. Releasing it again restarts the whole sequence from the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_cs_n_i | input | 1 | Host chip select, used after init |
| host_ras_n_i | input | 1 | Host row strobe |
| host_cas_n_i | input | 1 | Host column strobe |
| host_we_n_i | input | 1 | Host write enable |
| host_cke_i | input | 1 | Host clock enable |
| host_addr_i | input | ADDR_W | Host address |
| host_ba_i | input | BA_W | Host bank address |
| sd_cke_o | output | 1 | Memory clock enable |
| sd_cs_n_o | output | 1 | Memory chip select |
| sd_ras_n_o | output | 1 | Memory row strobe |
| sd_cas_n_o | output | 1 | Memory column strobe |
| sd_we_n_o | output | 1 | Memory write enable |
| sd_addr_o | output | ADDR_W | Memory address |
| sd_ba_o | output | BA_W | Memory bank address |
| init_done_o | output | 1 | Sequence finished; selects the host bus |

## Verification
The full sequence is run three times. In each run the host inputs are held at a read-like command with CKE low and nonzero address and bank, which separates a correct sequencer output from a leak of the host bus. After done rises, the host inputs step through a changing pattern of commands, addresses and banks, and every value must appear on the pins in the same cycle. One run is cut by a reset inside the first refresh wait, to show that the pins return to NOP at once and that the next release replays the stall from the beginning. The cycle of each command is compared with counts the bench derives itself, so a wait that is off by one cycle shows up as a mismatch.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_STALL, ST_PRE, ST_WAIT_RP, ST_REF1, ST_WAIT_RFC1,
    ST_REF2, ST_WAIT_RFC2, ST_LMR, ST_WAIT_MRD, ST_DONE
  } init_state_e;

  typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_LMR} init_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP = 4'b0111;
  localparam sdram_cmd_t CMD_PRE = 4'b0010;
  localparam sdram_cmd_t CMD_REF = 4'b0001;
  localparam sdram_cmd_t CMD_LMR = 4'b0000;

  // ceil(ns * f) with a 2-cycle floor so every command is followed by NOP
  function automatic int ns_to_cyc(input int ns, input int khz);
    int c;
    c = (ns * khz + 999999) / 1000000;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int               CNT_W   = 14,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RST_VAL;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int STALL_CYC = 10000,
  parameter int RP_CYC    = 2,
  parameter int RFC_CYC   = 7,
  parameter int MRD_CYC   = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output init_op_e op_o,
  output logic     done_o
);

  localparam logic [CNT_W-1:0] STALL_LD = CNT_W'(STALL_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD    = CNT_W'(RP_CYC - 2);
  localparam logic [CNT_W-1:0] RFC_LD   = CNT_W'(RFC_CYC - 2);
  localparam logic [CNT_W-1:0] MRD_LD   = CNT_W'(MRD_CYC - 2);

  init_state_e      state_q, state_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_zero;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(STALL_LD)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    op_o    = OP_NOP;
    unique case (state_q)
      ST_STALL:     if (tmr_zero) state_d = ST_PRE;
      ST_PRE:       begin op_o = OP_PRE; ld = 1'b1; ld_val = RP_LD;  state_d = ST_WAIT_RP;   end
      ST_WAIT_RP:   if (tmr_zero) state_d = ST_REF1;
      ST_REF1:      begin op_o = OP_REF; ld = 1'b1; ld_val = RFC_LD; state_d = ST_WAIT_RFC1; end
      ST_WAIT_RFC1: if (tmr_zero) state_d = ST_REF2;
      ST_REF2:      begin op_o = OP_REF; ld = 1'b1; ld_val = RFC_LD; state_d = ST_WAIT_RFC2; end
      ST_WAIT_RFC2: if (tmr_zero) state_d = ST_LMR;
      ST_LMR:       begin op_o = OP_LMR; ld = 1'b1; ld_val = MRD_LD; state_d = ST_WAIT_MRD;  end
      ST_WAIT_MRD:  if (tmr_zero) state_d = ST_DONE;
      ST_DONE:      state_d = ST_DONE;
      default:      state_d = ST_STALL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STALL;
    else         state_q <= state_d;
  end

  assign done_o = (state_q == ST_DONE);

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R7
  done_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tmr_zero));

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int               ADDR_W  = 13,
  parameter int               BA_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_A = '0,
  parameter logic [BA_W-1:0]   MODE_B = '0
) (
  input  init_op_e          op_i,
  output sdram_cmd_t        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  localparam logic [ADDR_W-1:0] A_ALL_BANKS = ADDR_W'(1) << 10;

  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (op_i)
      OP_PRE:  begin cmd_o = CMD_PRE; addr_o = A_ALL_BANKS; end
      OP_REF:  cmd_o = CMD_REF;
      OP_LMR:  begin cmd_o = CMD_LMR; addr_o = MODE_A; ba_o = MODE_B; end
      default: cmd_o = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int STALL_US  = 100,
  parameter int T_RP_NS   = 20,
  parameter int T_RFC_NS  = 70,
  parameter int T_MRD_CYC = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int MODE_VAL  = 'h033,
  parameter int MODE_BA   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_n_i,
  input  logic              host_ras_n_i,
  input  logic              host_cas_n_i,
  input  logic              host_we_n_i,
  input  logic              host_cke_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BA_W-1:0]   host_ba_i,
  output logic              sd_cke_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic              init_done_o
);

  localparam int STALL_CYC = STALL_US * CLK_KHZ / 1000;
  localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_KHZ);
  localparam int RFC_CYC   = ns_to_cyc(T_RFC_NS, CLK_KHZ);
  localparam int MRD_CYC   = (T_MRD_CYC < 2) ? 2 : T_MRD_CYC;
  localparam int MAX_W1    = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int MAX_W2    = (MAX_W1 > MRD_CYC) ? MAX_W1 : MRD_CYC;
  localparam int MAX_CYC   = (STALL_CYC > MAX_W2) ? STALL_CYC : MAX_W2;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  init_op_e          op;
  logic              done;
  sdram_cmd_t        init_cmd, host_cmd;
  logic [ADDR_W-1:0] init_addr;
  logic [BA_W-1:0]   init_ba;

  sdram_init_fsm #(
    .CNT_W(CNT_W), .STALL_CYC(STALL_CYC), .RP_CYC(RP_CYC),
    .RFC_CYC(RFC_CYC), .MRD_CYC(MRD_CYC)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_o   (op),
    .done_o (done)
  );

  sdram_init_cmd_enc #(
    .ADDR_W(ADDR_W), .BA_W(BA_W),
    .MODE_A(ADDR_W'(MODE_VAL)), .MODE_B(BA_W'(MODE_BA))
  ) u_enc (
    .op_i   (op),
    .cmd_o  (init_cmd),
    .addr_o (init_addr),
    .ba_o   (init_ba)
  );

  assign host_cmd = '{host_cs_n_i, host_ras_n_i, host_cas_n_i, host_we_n_i};

  // bus handoff: sequencer owns the pins until done
  always_comb begin
    if (done) begin
      {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = host_cmd;
      sd_cke_o  = host_cke_i;
      sd_addr_o = host_addr_i;
      sd_ba_o   = host_ba_i;
    end else begin
      {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = init_cmd;
      sd_cke_o  = 1'b1;
      sd_addr_o = init_addr;
      sd_ba_o   = init_ba;
    end
  end

  assign init_done_o = done;

  // R3
  pre_all_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && init_cmd == CMD_PRE) |-> sd_addr_o[10]);

  // R7
  cmd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && init_cmd != CMD_NOP) |=> (init_cmd == CMD_NOP || init_done_o));

  // R7
  cke_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> sd_cke_o);

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int AW   = 13;
  localparam int BW   = 2;
  // expected counts at 100 MHz: 100 us, 20 ns, 70 ns, 2 cycles
  localparam int E_ST  = 10000;
  localparam int E_RP  = 2;
  localparam int E_RFC = 7;
  localparam int E_MRD = 2;
  localparam int T_PRE = E_ST;
  localparam int T_RF1 = T_PRE + E_RP;
  localparam int T_RF2 = T_RF1 + E_RFC;
  localparam int T_LMR = T_RF2 + E_RFC;
  localparam int T_DN  = T_LMR + E_MRD;

  typedef struct {
    logic [3:0]    cmd;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;
    logic          cke;
    logic          done;
    logic [3:0]    h_cmd;
    logic [AW-1:0] h_addr;
    logic [BW-1:0] h_ba;
    logic          h_cke;
    string         tag;
  } item_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic h_cs, h_ras, h_cas, h_we, h_cke;
  logic [AW-1:0] h_addr;
  logic [BW-1:0] h_ba;
  logic sd_cke, sd_cs, sd_ras, sd_cas, sd_we, done;
  logic [AW-1:0] sd_addr;
  logic [BW-1:0] sd_ba;

  int tests = 0, fails = 0;
  bit mon_en = 1'b0;
  item_t q[$];
  item_t it;

  always #5 clk = ~clk;

  sdram_init_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_cs_n_i(h_cs), .host_ras_n_i(h_ras), .host_cas_n_i(h_cas), .host_we_n_i(h_we),
    .host_cke_i(h_cke), .host_addr_i(h_addr), .host_ba_i(h_ba),
    .sd_cke_o(sd_cke), .sd_cs_n_o(sd_cs), .sd_ras_n_o(sd_ras), .sd_cas_n_o(sd_cas),
    .sd_we_n_o(sd_we), .sd_addr_o(sd_addr), .sd_ba_o(sd_ba), .init_done_o(done)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_pins(string tag, logic [3:0] cmd, logic [AW-1:0] a, logic [BW-1:0] b,
                            logic cke, logic dn);
    check(tag, "cmd",  {28'd0, sd_cs, sd_ras, sd_cas, sd_we}, {28'd0, cmd});
    check(tag, "addr", 32'(sd_addr), 32'(a));
    check(tag, "ba",   32'(sd_ba), 32'(b));
    check(tag, "cke",  32'(sd_cke), 32'(cke));
    check(tag, "done", 32'(done), 32'(dn));
  endtask

  // driver: expected trace for samples n = 0..last (n = rising edges since release)
  task automatic push_trace(int last, int seed);
    for (int n = 0; n <= last; n++) begin
      item_t e;
      e.h_cmd = 4'b0101; e.h_addr = AW'('h1abc); e.h_ba = 2'd3; e.h_cke = 1'b0;
      e.cmd = 4'b0111; e.addr = '0; e.ba = '0; e.cke = 1'b1; e.done = 1'b0;
      if (n == 0)          e.tag = "R1";
      else if (n < T_PRE)  e.tag = "R2";
      else                 e.tag = "R7";
      if (n == T_PRE) begin e.cmd = 4'b0010; e.addr = AW'(1) << 10; e.tag = "R3"; end
      if (n == T_RF1) begin e.cmd = 4'b0001; e.tag = "R4"; end
      if (n == T_RF2) begin e.cmd = 4'b0001; e.tag = "R5"; end
      if (n == T_LMR) begin e.cmd = 4'b0000; e.addr = AW'('h033); e.tag = "R6"; end
      if (n >= T_DN) begin
        e.h_cmd  = 4'(n + seed);
        e.h_addr = AW'((n + seed) * 29);
        e.h_ba   = BW'(n + seed);
        e.h_cke  = 1'(n ^ seed);
        e.cmd = e.h_cmd; e.addr = e.h_addr; e.ba = e.h_ba; e.cke = e.h_cke; e.done = 1'b1;
        e.tag = (n == T_DN) ? "R7" : "R8";
      end
      q.push_back(e);
    end
  endtask

  // monitor: drives host stimulus of the item, then compares the pins
  always @(negedge clk) begin
    #1;
    if (mon_en && q.size() > 0) begin
      it = q.pop_front();
      {h_cs, h_ras, h_cas, h_we} = it.h_cmd;
      h_addr = it.h_addr; h_ba = it.h_ba; h_cke = it.h_cke;
      #1;
      check_pins(it.tag, it.cmd, it.addr, it.ba, it.cke, it.done);
    end
  end

  initial begin
    {h_cs, h_ras, h_cas, h_we} = 4'b0101;
    h_cke = 1'b0; h_addr = AW'('h1abc); h_ba = 2'd3;
    repeat (3) @(negedge clk);
    #2 check_pins("R1", 4'b0111, '0, '0, 1'b1, 1'b0);

    // run A: full sequence, then host passthrough
    @(negedge clk);
    push_trace(T_DN + 40, 3);
    rst_ni = 1'b1; mon_en = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);

    // run B: reset inside the first refresh wait (R9)
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    {h_cs, h_ras, h_cas, h_we} = 4'b0101; h_cke = 1'b0;
    push_trace(T_RF1 + 3, 0);
    rst_ni = 1'b1;
    wait (q.size() == 0);
    @(posedge clk); #3;
    rst_ni = 1'b0;
    #1 check_pins("R9", 4'b0111, '0, '0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);

    // run C: restart from the stall after the abort (R9)
    push_trace(T_DN + 60, 11);
    rst_ni = 1'b1;
    wait (q.size() == 0);
    @(negedge clk); #3;
    check("R9", "done_after_restart", 32'(done), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog actual=timeout expected=sequence_end");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule